// File: doc/BRIEF.md
# Masked-Compare Interval Timer

This block is a register-programmed timer built around a free-running 32-bit time base. The time base advances by one on every clock. It wraps from all ones to zero. Software can load it, and two separate synchronous request lines can zero it. Five compare channels watch the time base. Each channel has a 32-bit target and a 32-bit ignore mask, so it can fire on any chosen subset of time-base bits. With a partial mask, the channel fires periodically instead of once per wrap.

Two capture channels take asynchronous event inputs. Each input passes through a two-stage synchronizer. On the selected edge (rising, falling or both), the channel records the current time base. Compare and capture events set sticky status bits, which software clears by writing ones. A single interrupt line is the OR of the status bits that are both enabled and not masked.

Register map (byte offsets): 0x00 time base (R/W); 0x04 status (write 1 to clear); 0x08 interrupt enable; 0x0C interrupt mask; 0x10 capture control; 0x20 + 4k capture value k (read-only); 0x80 + 4c compare target c; 0xC0 + 4c compare ignore mask c. Status, enable and mask share one layout: bit c (0..4) belongs to compare channel c, and bit 5 + k belongs to capture channel k.

Top module: `gp_timer`

## Requirements
- R1: With no write or reset, the time base at offset 0x00 reads one higher on every clock, and it goes from 0xFFFFFFFF to 0x00000000.
- R2: A write to offset 0x00 loads the written value at that clock edge in place of the increment. Counting then resumes from the written value.
- R3: `rst` and `full_rst_req` synchronously clear every register to zero. `base_rst_req` synchronously clears only the time base and wins over a time-base write in the same cycle.
- R4: The compare targets at 0x80 + 4c and ignore masks at 0xC0 + 4c (c = 0..4) read back as written. Unmapped offsets read zero.
- R5: Status bit c rises one clock after the cycle in which the time base first equals target c on every bit position whose ignore-mask bit is 0. A mask bit of 1 excludes that position. The bit stays set while the match persists.
- R6: Writing offset 0x04 clears each status bit written as 1. A new event in the same cycle keeps its bit set.
- R7: Capture control at 0x10 uses bits [4k+2:4k] for channel k: bit 4k enables it, bit 4k+1 selects rising edges and bit 4k+2 selects falling edges. An input change is seen after two synchronizer stages. On the detected edge, the time base of that cycle is stored at 0x20 + 4k and status bit 5 + k is set.
- R8: A capture channel whose enable bit is 0 neither updates its capture value nor sets its status bit.
- R9: `irq` is high exactly when some status bit is 1, its enable bit at 0x08 is 1 and its mask bit at 0x0C is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| full_rst_req | input | 1 | Request to clear the whole timer |
| base_rst_req | input | 1 | Request to clear the time base only |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| cap_in | input | 2 | Asynchronous capture event inputs |
| irq | output | 1 | Interrupt request |

## Verification
Register writes and time-base loads appear on `rdata` one clock after the write edge. A compare status bit appears one clock after the first matching cycle. A capture appears three clocks after the input changes: two synchronizer edges plus the latch edge. The capture holds the time base from the cycle before that latch edge. `irq` follows status, enable and mask with no added delay. The bench steps a behavioural model on each rising edge with the same sampled inputs. It compares `rdata` and `irq` midway through the low phase, so every one of these delays is checked on the exact cycle it is due.

// File: rtl/gp_timer.sv
module gp_timer #(
  parameter int N_CMP = 5,
  parameter int N_CAP = 2,
  parameter int AW    = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             full_rst_req,
  input  logic             base_rst_req,
  input  logic             wr_en,
  input  logic [AW-1:0]    addr,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata,
  input  logic [N_CAP-1:0] cap_in,
  output logic             irq
);
  localparam int NST = N_CMP + N_CAP;
  localparam int CW  = 4 * N_CAP;
  localparam logic [AW-1:0] A_TB  = AW'(32'h00);
  localparam logic [AW-1:0] A_ST  = AW'(32'h04);
  localparam logic [AW-1:0] A_IEN = AW'(32'h08);
  localparam logic [AW-1:0] A_IMK = AW'(32'h0C);
  localparam logic [AW-1:0] A_CCT = AW'(32'h10);

  logic [31:0]      tb;
  logic [31:0]      cmp_val [N_CMP];
  logic [31:0]      cmp_msk [N_CMP];
  logic [31:0]      cap_val [N_CAP];
  logic [NST-1:0]   status, ien, imsk;
  logic [CW-1:0]    cap_ctl;
  logic [N_CAP-1:0] s1, s2, s3, cap_ev;
  logic [N_CMP-1:0] hit, hit_q;

  wire clear_all = rst | full_rst_req;
  wire wr_tb     = wr_en && addr == A_TB;
  wire [NST-1:0] clr = (wr_en && addr == A_ST) ? wdata[NST-1:0] : '0;
  wire [NST-1:0] set = {cap_ev, hit & ~hit_q};

  always_comb
    for (int c = 0; c < N_CMP; c++)
      hit[c] = ((tb ^ cmp_val[c]) & ~cmp_msk[c]) == 32'd0;

  always_comb
    for (int k = 0; k < N_CAP; k++)
      cap_ev[k] = cap_ctl[4*k] & ((cap_ctl[4*k+1] & s2[k] & ~s3[k]) |
                                  (cap_ctl[4*k+2] & ~s2[k] & s3[k]));

  always_ff @(posedge clk) begin
    if (clear_all) begin
      tb      <= '0;
      status  <= '0;
      ien     <= '0;
      imsk    <= '0;
      cap_ctl <= '0;
      hit_q   <= '0;
      s1      <= '0;
      s2      <= '0;
      s3      <= '0;
      for (int c = 0; c < N_CMP; c++) begin
        cmp_val[c] <= '0;
        cmp_msk[c] <= '0;
      end
      for (int k = 0; k < N_CAP; k++) cap_val[k] <= '0;
    end else begin
      if (base_rst_req)  tb <= '0;
      else if (wr_tb)    tb <= wdata;
      else               tb <= tb + 32'd1;
      status <= (status & ~clr) | set;
      hit_q  <= hit;
      s1     <= cap_in;
      s2     <= s1;
      s3     <= s2;
      if (wr_en && addr == A_IEN) ien     <= wdata[NST-1:0];
      if (wr_en && addr == A_IMK) imsk    <= wdata[NST-1:0];
      if (wr_en && addr == A_CCT) cap_ctl <= wdata[CW-1:0];
      for (int c = 0; c < N_CMP; c++) begin
        if (wr_en && addr == AW'(32'h80 + 4*c)) cmp_val[c] <= wdata;
        if (wr_en && addr == AW'(32'hC0 + 4*c)) cmp_msk[c] <= wdata;
      end
      for (int k = 0; k < N_CAP; k++)
        if (cap_ev[k]) cap_val[k] <= tb;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_TB:    rdata = tb;
      A_ST:    rdata = 32'(status);
      A_IEN:   rdata = 32'(ien);
      A_IMK:   rdata = 32'(imsk);
      A_CCT:   rdata = 32'(cap_ctl);
      default: ;
    endcase
    for (int k = 0; k < N_CAP; k++)
      if (addr == AW'(32'h20 + 4*k)) rdata = cap_val[k];
    for (int c = 0; c < N_CMP; c++) begin
      if (addr == AW'(32'h80 + 4*c)) rdata = cmp_val[c];
      if (addr == AW'(32'hC0 + 4*c)) rdata = cmp_msk[c];
    end
  end

  assign irq = |(status & ien & ~imsk);

  // R1
  tb_inc_chk: assert property (@(posedge clk) disable iff (rst)
    (!full_rst_req && !base_rst_req && !wr_tb) |=> tb == $past(tb) + 32'd1);

  // R2
  tb_load_chk: assert property (@(posedge clk) disable iff (rst)
    (!full_rst_req && !base_rst_req && wr_tb) |=> tb == $past(wdata));

  // R3
  tb_clear_chk: assert property (@(posedge clk) disable iff (rst)
    base_rst_req |=> tb == 32'd0);

  // R5
  hit_flag_chk: assert property (@(posedge clk) disable iff (rst)
    !full_rst_req |=>
      (status[N_CMP-1:0] & $past(hit & ~hit_q)) == $past(hit & ~hit_q));

  // R9
  quiet_irq_chk: assert property (@(posedge clk) disable iff (rst)
    (status == '0) |-> !irq);
endmodule

// File: tb/gp_timer_test.sv
module gp_timer_test;
  logic        clk = 0;
  logic        rst = 1, full_rst_req = 0, base_rst_req = 0, wr_en = 0;
  logic [7:0]  addr = 0;
  logic [31:0] wdata = 0;
  logic [1:0]  cap_in = 0;
  logic [31:0] rdata;
  logic        irq;

  always #4 clk = ~clk;

  gp_timer uut (.clk(clk), .rst(rst), .full_rst_req(full_rst_req),
    .base_rst_req(base_rst_req), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .cap_in(cap_in), .irq(irq));

  // behavioural reference state
  logic [31:0] m_tb = 0;
  logic [31:0] m_cmp [5];
  logic [31:0] m_msk [5];
  logic [31:0] m_cap [2];
  logic [6:0]  m_st = 0, m_ien = 0, m_imk = 0;
  logic [7:0]  m_cct = 0;
  logic [1:0]  m_s1 = 0, m_s2 = 0, m_s3 = 0;
  logic [4:0]  m_hq = 0;
  int vectors = 0, misses = 0;
  bit started = 0;
  string phase = "R1";

  initial begin
    for (int i = 0; i < 5; i++) begin m_cmp[i] = 0; m_msk[i] = 0; end
    for (int i = 0; i < 2; i++) m_cap[i] = 0;
  end

  always @(posedge clk) begin
    logic [6:0] setv;
    if (rst) started = 1;
    if (rst || full_rst_req) begin
      m_tb = 0; m_st = 0; m_ien = 0; m_imk = 0; m_cct = 0;
      m_s1 = 0; m_s2 = 0; m_s3 = 0; m_hq = 0;
      for (int i = 0; i < 5; i++) begin m_cmp[i] = 0; m_msk[i] = 0; end
      for (int i = 0; i < 2; i++) m_cap[i] = 0;
    end else begin
      setv = 0;
      for (int c = 0; c < 5; c++) begin
        bit eq;
        eq = 1;
        for (int b = 0; b < 32; b++)
          if (!m_msk[c][b] && m_tb[b] != m_cmp[c][b]) eq = 0;
        if (eq && !m_hq[c]) setv[c] = 1;
        m_hq[c] = eq;
      end
      for (int k = 0; k < 2; k++) begin
        bit up, dn;
        up = m_s2[k] && !m_s3[k];
        dn = !m_s2[k] && m_s3[k];
        if (m_cct[4*k] && ((m_cct[4*k+1] && up) || (m_cct[4*k+2] && dn))) begin
          setv[5+k] = 1;
          m_cap[k] = m_tb;
        end
      end
      if (wr_en && addr == 8'h04) m_st = m_st & ~wdata[6:0];
      m_st = m_st | setv;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = cap_in;
      if (base_rst_req) m_tb = 0;
      else if (wr_en && addr == 8'h00) m_tb = wdata;
      else m_tb = m_tb + 1;
      if (wr_en) begin
        if (addr == 8'h08) m_ien = wdata[6:0];
        if (addr == 8'h0C) m_imk = wdata[6:0];
        if (addr == 8'h10) m_cct = wdata[7:0];
        for (int c = 0; c < 5; c++) begin
          if (addr == 8'h80 + 8'(4*c)) m_cmp[c] = wdata;
          if (addr == 8'hC0 + 8'(4*c)) m_msk[c] = wdata;
        end
      end
    end
  end

  function automatic logic [31:0] m_read(logic [7:0] a);
    if (a == 8'h00) return m_tb;
    if (a == 8'h04) return 32'(m_st);
    if (a == 8'h08) return 32'(m_ien);
    if (a == 8'h0C) return 32'(m_imk);
    if (a == 8'h10) return 32'(m_cct);
    if (a == 8'h20) return m_cap[0];
    if (a == 8'h24) return m_cap[1];
    for (int c = 0; c < 5; c++) begin
      if (a == 8'h80 + 8'(4*c)) return m_cmp[c];
      if (a == 8'hC0 + 8'(4*c)) return m_msk[c];
    end
    return 0;
  endfunction

  function automatic string reg_tag(logic [7:0] a);
    if (a == 8'h00) return "R1";
    if (a == 8'h04) return "R6";
    if (a == 8'h08 || a == 8'h0C) return "R9";
    if (a == 8'h10) return "R8";
    if (a == 8'h20 || a == 8'h24) return "R7";
    if (a >= 8'h80 && a <= 8'hD0) return "R4";
    return "R4";
  endfunction

  always @(negedge clk) begin
    #2;
    if (started) begin
      logic [31:0] exp_d;
      logic exp_i;
      exp_d = m_read(addr);
      exp_i = |(m_st & m_ien & ~m_imk);
      vectors++;
      if (rdata !== exp_d) begin
        misses++;
        $display("FAIL %s/%s rdata @%02h: actual %08h expected %08h",
                 phase, reg_tag(addr), addr, rdata, exp_d);
      end
      if (irq !== exp_i) begin
        misses++;
        $display("FAIL R9 irq (%s): actual %0b expected %0b", phase, irq, exp_i);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [7:0] a, input int n);
    @(negedge clk); addr = a;
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_up;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    misses++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    phase = "R1"; rd(8'h00, 6);
    phase = "R2"; wr(8'h00, 32'hFFFF_FFFD);
    phase = "R1"; rd(8'h00, 6);
    phase = "R4";
    for (int c = 0; c < 5; c++) begin
      wr(8'h80 + 8'(4*c), 32'hA500_0000 + 32'(c));
      wr(8'hC0 + 8'(4*c), 32'hFFFF_FFFF);
    end
    for (int c = 0; c < 5; c++) begin
      rd(8'h80 + 8'(4*c), 1); rd(8'hC0 + 8'(4*c), 1);
    end
    rd(8'h14, 1); rd(8'h94, 1); rd(8'hE0, 1); rd(8'h28, 1);
    phase = "R5";
    wr(8'h04, 32'h7F);
    wr(8'hC0, 32'h0); wr(8'h80, 32'h0000_0100);
    wr(8'hC4, 32'hFFFF_FFF0); wr(8'h84, 32'h0000_0005);
    wr(8'hC8, 32'h0); wr(8'h88, 32'h1234_5678);
    wr(8'h00, 32'h0000_00F0);
    rd(8'h04, 40);
    phase = "R6"; wr(8'h04, 32'h01); rd(8'h04, 3);
    wr(8'h04, 32'h02); rd(8'h04, 20);
    phase = "R9";
    wr(8'h08, 32'h03); rd(8'h04, 4);
    wr(8'h0C, 32'h01); rd(8'h04, 20);
    wr(8'h0C, 32'h03); rd(8'h0C, 3);
    wr(8'h08, 32'h60); wr(8'h0C, 32'h00);
    phase = "R7";
    wr(8'h10, 32'h0000_0063);
    @(negedge clk); cap_in = 2'b11; rd(8'h20, 6);
    rd(8'h24, 2); rd(8'h04, 2);
    @(negedge clk); cap_in = 2'b00; rd(8'h20, 6);
    rd(8'h24, 2);
    phase = "R8";
    wr(8'h04, 32'h7F);
    wr(8'h10, 32'h0000_0005);
    @(negedge clk); cap_in = 2'b11; rd(8'h24, 6); rd(8'h20, 2);
    @(negedge clk); cap_in = 2'b00; rd(8'h20, 6); rd(8'h04, 2);
    phase = "R7";
    wr(8'h10, 32'h0000_0070);
    @(negedge clk); cap_in = 2'b10; rd(8'h24, 6);
    @(negedge clk); cap_in = 2'b00; rd(8'h24, 6); rd(8'h04, 2);
    phase = "R3";
    @(negedge clk); base_rst_req = 1; wr_en = 1; addr = 8'h00; wdata = 32'h5555_0000;
    @(negedge clk); base_rst_req = 0; wr_en = 0;
    rd(8'h00, 4); rd(8'h88, 1); rd(8'h08, 1);
    @(negedge clk); full_rst_req = 1;
    @(negedge clk); full_rst_req = 0;
    rd(8'h88, 1); rd(8'h08, 1); rd(8'h24, 1); rd(8'h00, 3); rd(8'h04, 2);
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    rd(8'h00, 3);
    finish_up();
  end
endmodule